// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps one enable bit and one pending bit for each of 200 interrupt sources. Software sees the enable bits through a small register bus. There are two windows of 32-bit words. Writing ones into the set window turns sources on. Writing ones into the clear window turns them off. Writing zeros into either window changes nothing. Both windows read back the same enable state.

Each request line that is sampled high marks its source pending, whether or not the source is enabled. The block presents the lowest-numbered source that is both pending and enabled, together with a valid flag. An acknowledge drops that source's pending bit. Only privileged accesses reach the registers. Any other access is refused and reported on a one-cycle error pulse.

Top module: `irq_enable_bank`

## Requirements
- R1: After reset all enable and pending bits are 0, `req_valid` is 0, `bus_rdata` is 0 and `bus_err` is 0.
- R2: A privileged write to byte address 0x100+4k (k = 0..6) sets the enable of source 32k+n for each bit n that is 1 in `bus_wdata`. Bits that are 0 leave their enables unchanged.
- R3: A privileged write to byte address 0x180+4k clears the enable of source 32k+n for each bit n that is 1. Bits that are 0 leave their enables unchanged.
- R4: A privileged read of 0x100+4k or of 0x180+4k returns the enable bits of sources 32k..32k+31 on `bus_rdata`, in the cycle after the read strobe. In any cycle that does not follow a privileged read of a window word, `bus_rdata` is 0.
- R5: Bits 8 to 31 of word 6 in both windows read as 0 and ignore writes. An address outside both windows, or one whose low two bits are not 00, reads as 0 and a write to it has no effect.
- R6: An access with `bus_priv` low does not change any enable bit and reads as 0. For each such access, `bus_err` is 1 for exactly the following cycle.
- R7: A source whose `irq_in` bit is sampled high at a clock edge is pending from that edge on, whether or not it is enabled.
- R8: `req_valid` is 1 exactly when some source is both pending and enabled. `req_id` then gives the lowest such source number. A pending source that is disabled is never presented.
- R9: With `req_valid` high, `req_ack` at a clock edge clears the pending bit of the presented source, unless that source's `irq_in` bit is still high. With `req_valid` low, `req_ack` has no effect.
- R10: A source that became pending while disabled is presented in the cycle after a write enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_priv | input | 1 | High for a privileged access |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an unprivileged access |
| irq_in | input | 200 | Per-source request lines |
| req_valid | output | 1 | Some source is pending and enabled |
| req_id | output | 8 | Lowest pending and enabled source number |
| req_ack | input | 1 | Acknowledge of the presented source |

## Verification
Read data and the error pulse are due one cycle after the strobe. Enable and pending changes appear on `req_valid` and `req_id` as soon as the clock edge that registers them has passed, with no further delay.

The driver tasks change inputs on the falling edge. For every access they queue the expected read word and error flag. The monitor notes at the rising edge whether a strobe was present and pops and compares the queued item at the next falling edge. Request checks are made at the falling edge after the edge that latched the pulse, acknowledge or write.

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_IRQ  = 200,
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 32,
  parameter int SET_BASE = 'h100,
  parameter int CLR_BASE = 'h180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_priv,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_err,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               req_valid,
  output logic [$clog2(NUM_IRQ)-1:0] req_id,
  input  logic               req_ack
);
  localparam int NUM_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;
  localparam int WA_W      = ADDR_W - 2;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int ID_W      = $clog2(NUM_IRQ);
  localparam int SH_W      = $clog2(PAD_W) + 1;
  localparam logic [WA_W-1:0] SET_W0 = WA_W'(SET_BASE / 4);
  localparam logic [WA_W-1:0] SET_W1 = WA_W'(SET_BASE / 4 + NUM_WORDS);
  localparam logic [WA_W-1:0] CLR_W0 = WA_W'(CLR_BASE / 4);
  localparam logic [WA_W-1:0] CLR_W1 = WA_W'(CLR_BASE / 4 + NUM_WORDS);

  logic [NUM_IRQ-1:0] en_q, pend_q, ready, wr_mask, ack_clr;
  logic [WA_W-1:0]    wa;
  logic [IDX_W-1:0]   idx;
  logic [SH_W-1:0]    shift;
  logic               aligned, set_hit, clr_hit, wr_ok, rd_ok;
  logic [PAD_W-1:0]   en_pad;
  logic [WORD_W-1:0]  rd_word;

  assign wa      = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign set_hit = aligned && (wa >= SET_W0) && (wa < SET_W1);
  assign clr_hit = aligned && (wa >= CLR_W0) && (wa < CLR_W1);
  assign idx     = set_hit ? IDX_W'(wa - SET_W0) : IDX_W'(wa - CLR_W0);
  assign shift   = SH_W'(idx) * SH_W'(WORD_W);
  assign wr_ok   = bus_wr && bus_priv;
  assign rd_ok   = bus_rd && bus_priv && (set_hit || clr_hit);
  assign wr_mask = NUM_IRQ'(PAD_W'(bus_wdata) << shift);
  assign en_pad  = PAD_W'(en_q);
  assign rd_word = WORD_W'(en_pad >> shift);
  assign ready   = pend_q & en_q;

  always_comb begin
    req_valid = 1'b0;
    req_id    = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (ready[i]) begin
        req_valid = 1'b1;
        req_id    = ID_W'(i);
      end
    end
  end

  assign ack_clr = (req_ack && req_valid) ? (NUM_IRQ'(1) << req_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (wr_ok && set_hit) en_q <= en_q | wr_mask;
      else if (wr_ok && clr_hit) en_q <= en_q & ~wr_mask;
      pend_q    <= (pend_q & ~ack_clr) | irq_in;
      bus_rdata <= rd_ok ? rd_word : '0;
      bus_err   <= (bus_rd || bus_wr) && !bus_priv;
    end
  end

  // R8
  presented_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend_q[req_id] && en_q[req_id]));
  // R7
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_in) |=> ((pend_q & $past(irq_in)) == $past(irq_in)));
  // R6
  unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv) |=> $stable(en_q));
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
  // R2
  set_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && set_hit) |=> ((en_q & $past(en_q)) == $past(en_q)));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_valid && !irq_in[req_id]) |=> !pend_q[$past(req_id)]);
endmodule

// File: tb/irq_enable_bank_tb_top.sv
`timescale 1ns/1ps
module irq_enable_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0, req_ack = 1'b0;
  logic [31:0]  bus_rdata;
  logic         bus_err, req_valid;
  logic [199:0] irq_in = '0;
  logic [7:0]   req_id;

  int checks = 0, fails = 0;
  logic [223:0] exp_en = '0;
  logic [31:0]  q_rd[$];
  logic         q_err[$];
  string        q_tag[$];

  irq_enable_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_in(irq_in), .req_valid(req_valid), .req_id(req_id),
    .req_ack(req_ack));

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int win_word(logic [11:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a >= 12'h100 && a < 12'h11C) return (a - 12'h100) / 4;
    if (a >= 12'h180 && a < 12'h19C) return (a - 12'h180) / 4;
    return -1;
  endfunction

  task automatic access(string tag, logic [11:0] a, logic [31:0] d, logic wr, logic priv);
    int k;
    logic [223:0] m;
    k = win_word(a);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = !wr; bus_priv = priv;
    if (!priv) begin
      q_rd.push_back('0); q_err.push_back(1'b1);
    end else if (!wr) begin
      q_rd.push_back(k < 0 ? 32'h0 : exp_en[k*32 +: 32]); q_err.push_back(1'b0);
    end else begin
      q_rd.push_back('0); q_err.push_back(1'b0);
      if (k >= 0) begin
        m = '0;
        m[k*32 +: 32] = d;
        m[223:200] = '0;
        if (a < 12'h180) exp_en = exp_en | m;
        else exp_en = exp_en & ~m;
      end
    end
    q_tag.push_back(tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq_in[n] = 1'b1;
    @(negedge clk); irq_in[n] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); req_ack = 1'b1;
    @(negedge clk); req_ack = 1'b0;
  endtask

  task automatic chk_req(string tag, logic v, logic [7:0] id);
    chk({tag, " valid"}, 32'(req_valid), 32'(v));
    if (v) chk({tag, " id"}, 32'(req_id), 32'(id));
  endtask

  initial begin : monitor
    logic acc;
    forever begin
      @(posedge clk);
      acc = bus_rd || bus_wr;
      @(negedge clk);
      if (acc && q_rd.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        chk({t, " rdata"}, bus_rdata, q_rd.pop_front());
        chk({t, " err"}, 32'(bus_err), 32'(q_err.pop_front()));
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 err", 32'(bus_err), 0);
    access("R1 word0", 12'h100, 0, 0, 1);
    access("R1 word6", 12'h118, 0, 0, 1);
    // R2 R4
    access("R2 set w0", 12'h100, 32'h5, 1, 1);
    access("R2 read set", 12'h100, 0, 0, 1);
    access("R4 read clr", 12'h180, 0, 0, 1);
    access("R2 zero write", 12'h100, 32'h0, 1, 1);
    access("R2 after zero", 12'h100, 0, 0, 1);
    // R3
    access("R3 zero write", 12'h180, 32'h0, 1, 1);
    access("R3 after zero", 12'h100, 0, 0, 1);
    access("R3 clear bit0", 12'h180, 32'h1, 1, 1);
    access("R3 after clear", 12'h100, 0, 0, 1);
    // R5
    access("R5 set w6", 12'h118, 32'hFFFF_FFFF, 1, 1);
    access("R5 read w6", 12'h118, 0, 0, 1);
    access("R5 read clr w6", 12'h198, 0, 0, 1);
    access("R2 set w2", 12'h108, 32'h8000_0001, 1, 1);
    access("R2 read w2", 12'h108, 0, 0, 1);
    access("R5 past end", 12'h11C, 0, 0, 1);
    access("R5 below", 12'h0FC, 0, 0, 1);
    access("R5 misaligned", 12'h101, 0, 0, 1);
    access("R5 misaligned wr", 12'h105, 32'hFFFF_FFFF, 1, 1);
    access("R5 after misaligned", 12'h104, 0, 0, 1);
    // R6
    access("R6 unpriv wr", 12'h104, 32'hFFFF_FFFF, 1, 0);
    access("R6 read back", 12'h104, 0, 0, 1);
    access("R6 unpriv rd", 12'h100, 0, 0, 0);
    access("R6 unpriv clr", 12'h180, 32'h4, 1, 0);
    access("R6 clr kept", 12'h100, 0, 0, 1);
    // R7 R8 R10
    pulse(10);
    chk_req("R7 disabled pending hidden", 0, 0);
    access("R10 enable 10", 12'h100, 32'h400, 1, 1);
    chk_req("R10 pending presented", 1, 10);
    irq_in[2] = 1'b1; irq_in[70] = 1'b1;
    @(negedge clk); irq_in[2] = 1'b0; irq_in[70] = 1'b0;
    chk_req("R8 lowest wins", 1, 2);
    ack();
    chk_req("R9 ack to next", 1, 10);
    ack();
    chk_req("R9 ack empties", 0, 0);
    access("R7 enable 70", 12'h108, 32'h40, 1, 1);
    chk_req("R7 kept pending", 1, 70);
    ack();
    chk_req("R9 ack 70", 0, 0);
    // R9 held line
    @(negedge clk); irq_in[199] = 1'b1;
    @(negedge clk);
    chk_req("R8 top source", 1, 199);
    ack();
    chk_req("R9 held stays", 1, 199);
    irq_in[199] = 1'b0;
    ack();
    chk_req("R9 released clears", 0, 0);
    // R9 ack without valid
    pulse(11);
    ack();
    access("R9 enable 11", 12'h100, 32'h800, 1, 1);
    chk_req("R9 idle ack ignored", 1, 11);
    pulse(95);
    chk_req("R8 lower still first", 1, 11);
    access("R3 disable 11", 12'h180, 32'h800, 1, 1);
    chk_req("R3 disabled skipped", 1, 95);
    ack();
    chk_req("R9 final", 0, 0);
    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(q_rd.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule